// File: doc/BRIEF.md
# Linked-Page Descriptor Ring Walker

This block serves one DMA queue whose descriptors live in host memory. The ring is a circular chain of 4 KB pages, each split into 32-byte slots. Software advances a tail index to give descriptors to hardware. The walker then reads one descriptor at a time from the slot at its head position through a single-outstanding memory-read port, and gathers the four 64-bit response beats into one 256-bit descriptor. A descriptor with its link flag set is not forwarded. The walker treats it as a pointer, jumps to the page it names and continues from that page's first slot. Every other descriptor goes to a data mover on a valid/ready stream. The head index advances only when the data mover accepts.

Head and tail count data descriptors only, and both wrap at a programmed ring length. The final link of the chain is expected to point back to the programmed base, so the page walk and the index wrap stay in step. A link that names an address not aligned to 4 KB stops the queue and raises a sticky error flag until reset.

Top module: `desc_ring_walker`

## Requirements
- R1: A synchronous active-high reset sets `head_idx` to 0, clears `err_flag`, and holds `rd_req_valid` and `dsc_valid` low. It also reloads the current page from `cfg_base`, so the first read after reset targets `cfg_base` exactly.
- R2: While the head index equals the tail index, no read request is issued.
- R3: A one-cycle `tail_wr` pulse loads `tail_wdata` as the new tail. Descriptors from the head index up to the tail index (tail excluded, modulo the ring length) are then forwarded in ring order, and exactly that many are forwarded.
- R4: Only one read is outstanding at a time. The request address is the current page plus 32 times the slot number, and is therefore 32-byte aligned. The address and valid stay stable until `rd_req_ready`. The response arrives as four beats, and beat k fills descriptor bits [64k+63:64k].
- R5: A descriptor whose bit 255 is 1 is a link. It is never forwarded. Its bits [63:0] become the new page address, and fetching continues at slot 0 of that page, including the final link back to the base.
- R6: If a link's next-page address has any of bits [11:0] set, `err_flag` goes high and stays high until reset. No further read requests or forwarded descriptors follow.
- R7: `head_idx` changes only in a cycle where `dsc_valid` and `dsc_ready` are both high. It then steps by one, and wraps from `cfg_ring_len`-1 to 0.
- R8: While `dsc_valid` is high and `dsc_ready` is low, `dsc_valid` stays high and `dsc_data` stays unchanged.
- R9: A tail write to an idle queue resumes fetching at the saved head slot on the current page. The base is not revisited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Address of the first ring page, 4 KB aligned |
| cfg_ring_len | input | IDX_W | Number of data descriptors in the ring |
| tail_wr | input | 1 | Tail register write strobe |
| tail_wdata | input | IDX_W | New tail index |
| head_idx | output | IDX_W | Head index, readable by software |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the 32-byte descriptor |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | BEAT_W | Response beat, lowest address first |
| dsc_valid | output | 1 | Data descriptor valid to the data mover |
| dsc_ready | input | 1 | Data mover accepts the descriptor |
| dsc_data | output | DESC_BYTES*8 | Assembled data descriptor |
| err_flag | output | 1 | Sticky misaligned-link error |

## Verification
A short tail advance on the first page shows whether the walker stops exactly at the tail. A second advance from an idle queue shows whether it resumes from the saved slot or falls back to the base. A long advance that crosses the mid-ring link and the final link back to the base separates correct link handling from forwarding links or losing the page, and it also exercises the index wrap. Random tail steps with random gaps between response beats and random back-pressure check ordering and data stability under timing variation. A separate ring with a misaligned link shows whether the queue halts after exactly the descriptors that come before the link.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

    typedef enum logic [2:0] {
        RW_IDLE,
        RW_REQ,
        RW_RSP,
        RW_DEC,
        RW_OUT,
        RW_HALT
    } rw_state_e;

endpackage

// File: rtl/ring_beat_pack.sv
module ring_beat_pack #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    beat_valid,
    input  logic [BEAT_W-1:0]       beat_data,
    output logic                    last_beat,
    output logic [BEAT_W*BEATS-1:0] desc
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (beat_valid) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_beat = beat_valid && (cnt_q == CNT_W'(BEATS - 1));

    // one register lane per beat, filled lowest address first
    for (genvar i = 0; i < BEATS; i++) begin : g_lane
        logic [BEAT_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (beat_valid && (cnt_q == CNT_W'(i))) begin
                lane_d = beat_data;
            end
        end

        always_ff @(posedge clk) begin
            lane_q <= lane_d;
        end

        assign desc[i*BEAT_W +: BEAT_W] = lane_q;
    end

endmodule

// File: rtl/ring_link_decode.sv
module ring_link_decode #(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 12
) (
    input  logic              link_bit,
    input  logic [ADDR_W-1:0] addr_word,
    output logic              is_link,
    output logic [ADDR_W-1:0] next_page,
    output logic              misaligned
);
    assign is_link    = link_bit;
    assign next_page  = addr_word;
    assign misaligned = |addr_word[OFS_W-1:0];
endmodule

// File: rtl/ring_idx_step.sv
module ring_idx_step #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] len,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W-1:0] inc;

    assign inc = idx + IDX_W'(1);
    assign nxt = (inc == len) ? '0 : inc;
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker #(
    parameter int ADDR_W     = 64,
    parameter int IDX_W      = 16,
    parameter int BEAT_W     = 64,
    parameter int DESC_BYTES = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         cfg_base,
    input  logic [IDX_W-1:0]          cfg_ring_len,
    input  logic                      tail_wr,
    input  logic [IDX_W-1:0]          tail_wdata,
    output logic [IDX_W-1:0]          head_idx,
    output logic                      rd_req_valid,
    input  logic                      rd_req_ready,
    output logic [ADDR_W-1:0]         rd_req_addr,
    input  logic                      rd_rsp_valid,
    input  logic [BEAT_W-1:0]         rd_rsp_data,
    output logic                      dsc_valid,
    input  logic                      dsc_ready,
    output logic [DESC_BYTES*8-1:0]   dsc_data,
    output logic                      err_flag
);
    import ring_walk_pkg::*;

    localparam int DESC_W   = DESC_BYTES * 8;
    localparam int BEATS    = DESC_W / BEAT_W;
    localparam int SLOTS    = PAGE_BYTES / DESC_BYTES;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int DOFS_W   = $clog2(DESC_BYTES);
    localparam int OFS_W    = $clog2(PAGE_BYTES);
    localparam int LINK_BIT = DESC_W - 1;

    typedef struct packed {
        rw_state_e         state;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [ADDR_W-1:0] page;
        logic [SLOT_W-1:0] slot;
        logic              err;
    } walk_t;

    walk_t c_d, c_q;

    logic [DESC_W-1:0] desc;
    logic              pack_last;
    logic              is_link;
    logic              link_bad;
    logic [ADDR_W-1:0] link_page;
    logic [IDX_W-1:0]  head_next;
    logic              req_fire;

    assign req_fire = (c_q.state == RW_REQ) && rd_req_ready;

    ring_beat_pack #(
        .BEAT_W (BEAT_W),
        .BEATS  (BEATS)
    ) u_pack (
        .clk        (clk),
        .rst        (rst),
        .start      (req_fire),
        .beat_valid (rd_rsp_valid && (c_q.state == RW_RSP)),
        .beat_data  (rd_rsp_data),
        .last_beat  (pack_last),
        .desc       (desc)
    );

    ring_link_decode #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_link (
        .link_bit   (desc[LINK_BIT]),
        .addr_word  (desc[ADDR_W-1:0]),
        .is_link    (is_link),
        .next_page  (link_page),
        .misaligned (link_bad)
    );

    ring_idx_step #(
        .IDX_W (IDX_W)
    ) u_step (
        .idx (c_q.head),
        .len (cfg_ring_len),
        .nxt (head_next)
    );

    always_comb begin
        c_d = c_q;
        if (tail_wr) begin
            c_d.tail = tail_wdata;
        end
        unique case (c_q.state)
            RW_IDLE: begin
                if (c_q.head != c_q.tail) begin
                    c_d.state = RW_REQ;
                end
            end
            RW_REQ: begin
                if (rd_req_ready) begin
                    c_d.state = RW_RSP;
                end
            end
            RW_RSP: begin
                if (pack_last) begin
                    c_d.state = RW_DEC;
                end
            end
            RW_DEC: begin
                if (is_link) begin
                    if (link_bad) begin
                        c_d.err   = 1'b1;
                        c_d.state = RW_HALT;
                    end else begin
                        c_d.page  = link_page;
                        c_d.slot  = '0;
                        c_d.state = RW_REQ;
                    end
                end else begin
                    c_d.state = RW_OUT;
                end
            end
            RW_OUT: begin
                if (dsc_ready) begin
                    c_d.head  = head_next;
                    c_d.slot  = c_q.slot + SLOT_W'(1);
                    c_d.state = RW_IDLE;
                end
            end
            RW_HALT: begin
                c_d.state = RW_HALT;
            end
            default: begin
                c_d.state = RW_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state <= RW_IDLE;
            c_q.head  <= '0;
            c_q.tail  <= '0;
            c_q.page  <= cfg_base;
            c_q.slot  <= '0;
            c_q.err   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign head_idx     = c_q.head;
    assign err_flag     = c_q.err;
    assign rd_req_valid = (c_q.state == RW_REQ);
    assign rd_req_addr  = c_q.page + (ADDR_W'(c_q.slot) << DOFS_W);
    assign dsc_valid    = (c_q.state == RW_OUT);
    assign dsc_data     = desc;

endmodule

// File: rtl/ring_walk_chk.sv
module ring_walk_chk #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 16,
    parameter int DESC_W = 256,
    parameter int BEATS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              rd_rsp_valid,
    input logic              dsc_valid,
    input logic              dsc_ready,
    input logic [DESC_W-1:0] dsc_data,
    input logic [IDX_W-1:0]  head_idx,
    input logic              err_flag
);
    localparam int CW   = $clog2(BEATS) + 1;
    localparam int DOFS = $clog2(DESC_W / 8);

    logic          busy_q;
    logic [CW-1:0] seen_q;

    // independent tracker of the read in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            seen_q <= '0;
        end else if (rd_req_valid && rd_req_ready) begin
            busy_q <= 1'b1;
            seen_q <= '0;
        end else if (busy_q && rd_rsp_valid) begin
            if (seen_q == CW'(BEATS - 1)) begin
                busy_q <= 1'b0;
            end
            seen_q <= seen_q + CW'(1);
        end
    end

    // R4
    one_read_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !rd_req_valid);

    // R4
    req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_req_addr[DOFS-1:0] == '0));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R8
    dsc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_data)));

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dsc_valid && dsc_ready) |=> $stable(head_idx));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (!rd_req_valid && !dsc_valid));

    // R5
    no_out_mid_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !dsc_valid);

endmodule

bind desc_ring_walker ring_walk_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DESC_W (DESC_BYTES * 8),
    .BEATS  (DESC_BYTES * 8 / BEAT_W)
) u_walk_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .dsc_valid    (dsc_valid),
    .dsc_ready    (dsc_ready),
    .dsc_data     (dsc_data),
    .head_idx     (head_idx),
    .err_flag     (err_flag)
);

// File: tb/desc_ring_walker_bench.sv
module desc_ring_walker_bench;

    localparam logic [63:0] BASE1 = 64'h0001_0000;
    localparam logic [63:0] PAGE2 = 64'h0002_3000;
    localparam logic [63:0] BASE2 = 64'h0004_0000;
    localparam logic [63:0] BADLK = 64'h0005_0010;
    localparam int          LEN1  = 132;

    logic         clk = 1'b0;
    logic         rst;
    logic [63:0]  cfg_base;
    logic [15:0]  cfg_ring_len;
    logic         tail_wr;
    logic [15:0]  tail_wdata;
    logic [15:0]  head_idx;
    logic         rd_req_valid;
    logic         rd_req_ready;
    logic [63:0]  rd_req_addr;
    logic         rd_rsp_valid;
    logic [63:0]  rd_rsp_data;
    logic         dsc_valid;
    logic         dsc_ready;
    logic [255:0] dsc_data;
    logic         err_flag;

    always #10ns clk = ~clk;

    desc_ring_walker u_desc_ring_walker (
        .clk          (clk),
        .rst          (rst),
        .cfg_base     (cfg_base),
        .cfg_ring_len (cfg_ring_len),
        .tail_wr      (tail_wr),
        .tail_wdata   (tail_wdata),
        .head_idx     (head_idx),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .dsc_valid    (dsc_valid),
        .dsc_ready    (dsc_ready),
        .dsc_data     (dsc_data),
        .err_flag     (err_flag)
    );

    int          checks   = 0;
    int          failures = 0;
    int          consumed = 0;
    int          exp_idx  = 0;
    int          ring_len_tb = LEN1;
    int          scen     = 1;
    int          req_count = 0;
    bit          grab     = 1'b0;
    logic [63:0] first_addr = '0;
    logic [63:0] mem [logic [63:0]];

    function automatic logic [63:0] dbeat(input logic [63:0] a, input int j);
        return {16'h55A7, 8'(j), 8'hC3, a[31:0]};
    endfunction

    function automatic logic [255:0] exp_desc(input logic [63:0] a);
        return {dbeat(a, 3), dbeat(a, 2), dbeat(a, 1), dbeat(a, 0)};
    endfunction

    function automatic logic [63:0] exp_addr(input int idx);
        if (scen == 1) begin
            if (idx < 127) return BASE1 + 64'(idx * 32);
            return PAGE2 + 64'((idx - 127) * 32);
        end
        return BASE2 + 64'(idx * 32);
    endfunction

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'hBAD0_BAD0_BAD0_BAD0;
    endfunction

    task automatic put_data(input logic [63:0] a);
        for (int j = 0; j < 4; j++) mem[a + 64'(j * 8)] = dbeat(a, j);
    endtask

    task automatic put_link(input logic [63:0] a, input logic [63:0] nxt);
        mem[a]      = nxt;
        mem[a + 8]  = '0;
        mem[a + 16] = '0;
        mem[a + 24] = 64'h8000_0000_0000_0000;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_tail(input int v);
        @(negedge clk);
        tail_wr    = 1'b1;
        tail_wdata = 16'(v);
        @(negedge clk);
        tail_wr    = 1'b0;
    endtask

    task automatic wait_for(input int target, input string req);
        int n = 0;
        while (consumed < target && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) check(1'b0, req, "timeout consumed", 64'(consumed), 64'(target));
        repeat (20) @(negedge clk);
    endtask

    // memory responder: single beat per cycle with random gaps
    initial begin
        int          beats_left;
        logic [63:0] rsp_addr;
        beats_left   = 0;
        rsp_addr     = '0;
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                rd_req_ready = 1'b0;
                rd_rsp_valid = 1'b0;
                beats_left   = 0;
                continue;
            end
            if (beats_left > 0 && ($urandom % 4) != 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem_rd(rsp_addr);
                rsp_addr     = rsp_addr + 8;
                beats_left--;
            end else begin
                rd_rsp_valid = 1'b0;
            end
            rd_req_ready = (beats_left == 0) && (($urandom % 2) == 0);
            if (rd_req_valid && rd_req_ready) begin
                rsp_addr   = rd_req_addr;
                beats_left = 4;
                req_count++;
                if (grab) begin
                    first_addr = rd_req_addr;
                    grab       = 1'b0;
                end
            end
        end
    end

    // data mover model with random back-pressure
    initial begin
        dsc_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin
                dsc_ready = 1'b0;
                continue;
            end
            dsc_ready = ($urandom % 3) != 0;
            if (dsc_valid && dsc_ready) begin
                logic [255:0] e;
                e = exp_desc(exp_addr(exp_idx));
                checks++;
                if (dsc_data !== e) begin
                    failures++;
                    $display("FAIL R3/R5 descriptor %0d actual=%h expected=%h", exp_idx, dsc_data, e);
                end
                exp_idx = (exp_idx + 1) % ring_len_tb;
                consumed++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int target;
        int cur;
        int rc;
        void'($urandom(32'd7031));
        rst          = 1'b1;
        tail_wr      = 1'b0;
        tail_wdata   = '0;
        cfg_base     = BASE1;
        cfg_ring_len = 16'(LEN1);
        for (int i = 0; i < 127; i++) put_data(BASE1 + 64'(i * 32));
        put_link(BASE1 + 64'(127 * 32), PAGE2);
        for (int i = 0; i < 5; i++) put_data(PAGE2 + 64'(i * 32));
        put_link(PAGE2 + 64'(5 * 32), BASE1);
        put_data(BASE2);
        put_data(BASE2 + 32);
        put_link(BASE2 + 64, BADLK);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(head_idx == 0, "R1", "head after reset", 64'(head_idx), 0);
        check(err_flag == 0, "R1", "err after reset", 64'(err_flag), 0);
        check(!rd_req_valid && !dsc_valid, "R1", "valids after reset",
              64'({rd_req_valid, dsc_valid}), 0);

        // R2 equal head and tail: no fetch
        repeat (30) @(negedge clk);
        check(req_count == 0, "R2", "requests while empty", 64'(req_count), 0);

        // R3 short advance, first fetch at base (R1)
        grab = 1'b1;
        write_tail(10);
        target = 10;
        wait_for(target, "R3");
        check(consumed == target, "R3", "forwarded count", 64'(consumed), 64'(target));
        check(head_idx == 10, "R7", "head after first batch", 64'(head_idx), 10);
        check(first_addr == BASE1, "R1", "first read address", first_addr, BASE1);
        rc = req_count;
        repeat (30) @(negedge clk);
        check(req_count == rc, "R2", "requests after catch-up", 64'(req_count), 64'(rc));

        // R9 resume from saved head
        grab = 1'b1;
        write_tail(20);
        target = 20;
        wait_for(target, "R9");
        check(first_addr == BASE1 + 64'(10 * 32), "R9", "resume address",
              first_addr, BASE1 + 64'(10 * 32));
        check(head_idx == 20, "R7", "head after resume", 64'(head_idx), 20);

        // R5 and R7: cross page link, final link and index wrap
        write_tail(5);
        target = target + (LEN1 - 20) + 5;
        wait_for(target, "R5");
        check(consumed == target, "R5", "links not forwarded", 64'(consumed), 64'(target));
        check(head_idx == 5, "R7", "head after wrap", 64'(head_idx), 5);

        // R3 random tail steps
        cur = 5;
        for (int k = 0; k < 6; k++) begin
            int step;
            step   = 1 + int'($urandom % 40);
            cur    = (cur + step) % LEN1;
            target = target + step;
            write_tail(cur);
            wait_for(target, "R3");
            check(consumed == target, "R3", "random batch count", 64'(consumed), 64'(target));
            check(head_idx == 16'(cur), "R7", "random batch head", 64'(head_idx), 64'(cur));
        end

        // R6 misaligned link on a second ring
        rst = 1'b1;
        @(negedge clk);
        cfg_base     = BASE2;
        cfg_ring_len = 16'd10;
        scen         = 2;
        ring_len_tb  = 10;
        consumed     = 0;
        exp_idx      = 0;
        req_count    = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(head_idx == 0 && !err_flag, "R1", "second reset state",
              64'({err_flag, head_idx}), 0);
        grab = 1'b1;
        write_tail(5);
        repeat (150) @(negedge clk);
        check(first_addr == BASE2, "R1", "reloaded base", first_addr, BASE2);
        check(consumed == 2, "R6", "descriptors before bad link", 64'(consumed), 2);
        check(err_flag == 1, "R6", "error flag", 64'(err_flag), 1);
        check(head_idx == 2, "R6", "head at halt", 64'(head_idx), 2);
        rc = req_count;
        repeat (30) @(negedge clk);
        check(req_count == rc && !rd_req_valid, "R6", "requests after error",
              64'(req_count), 64'(rc));
        check(err_flag == 1, "R6", "error still set", 64'(err_flag), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule